// File: doc/BRIEF.md
# Processor wait-state controller

This block carries out a privileged wait instruction for a processor core. When the decoder presents a wait instruction, the controller loads the program counter with the address after the instruction. It then raises a stall that holds back further instruction issue. The stall stays up until one of two release conditions is seen. The first is an interrupt activation. The second is the operator's compute switch making a complete trip from RUN to IDLE and back to RUN. When the stall lifts, execution goes on at the address that was already loaded. So an interrupt handler that returns, or a single-instruction interrupt location, also resumes after the wait.

If the wait is addressed indirectly and the indirect reference points at nonexistent memory, no wait takes place. The controller raises a nonallowed-operation trap with a fixed vector instead. The effective address is never used as a memory reference, so the block has no memory port. Input/output activity is outside this block and carries on untouched during the wait.

All pins are plain control and status pins, with no valid/ready streams. The switch level is asynchronous and is synchronized inside the block. The trap and program-counter load are one-cycle pulses, and resume marks the single release cycle.

Top module: `wait_state_ctrl`

## Requirements
- R1: After reset, stall, pc_load, trap_req and resume are all 0.
- R2: A wait issue (issue_valid=1 while stall=0) that is not a bad indirect reference gives, one clock later, a single-cycle pc_load=1 with pc_value equal to cur_pc+1 modulo 2^AW, and stall=1 in that same cycle.
- R3: A wait issue with is_indirect=1 and ind_ok=0 gives, one clock later, a single-cycle trap_req=1 with trap_vec=0x40. Neither stall nor pc_load is raised.
- R4: While waiting, stall stays 1 as long as irq is 0 and the switch does not finish a RUN-to-IDLE-to-RUN trip.
- R5: irq=1 sampled while stall=1 releases the wait at the next clock edge.
- R6: A switch trip from RUN (sw_run=1) to IDLE (sw_run=0) and back to RUN releases the wait. The release cycle comes three clocks after sw_run returns to 1, counting two synchronizer stages and the state register. IDLE alone does not release.
- R7: If the switch is already at IDLE when the wait starts, its return to RUN does not release the wait. A later move to IDLE and then back to RUN does.
- R8: A release shows as exactly one cycle with resume=1 and stall=0. After it resume is 0, and the block stays idle until the next issue. irq while not waiting has no effect.
- R9: issue_valid while stall=1 is ignored: it gives no pc_load and no trap_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Decoder presents a wait instruction this cycle |
| is_indirect | input | 1 | The instruction is indirectly addressed |
| ind_ok | input | 1 | The indirect reference address exists |
| cur_pc | input | AW | Address of the wait instruction |
| irq | input | 1 | Interrupt activation |
| sw_run | input | 1 | Compute switch level, 1 = RUN, 0 = IDLE (asynchronous) |
| stall | output | 1 | Holds instruction issue while waiting |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_value | output | AW | Value to load into the program counter |
| trap_req | output | 1 | One-cycle nonallowed-operation trap request |
| trap_vec | output | AW | Trap location (0x40) |
| resume | output | 1 | One-cycle pulse in the release cycle |

## Verification
The assertions check on every cycle the properties that follow from the state alone. The load strobe never repeats. A trap never comes with a stall or a load. The resume pulse lasts one cycle with stall low. An active irq during a stall always releases. A stall with no release event persists. A second issue during a stall does nothing. Only the bench scenarios can show the program-counter value and its wraparound, the trap vector, and the three-cycle switch latency. They also show the rule that an IDLE level present at entry does not count, which depends on the order of switch moves over many cycles.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_WAITING  = 2'd1,
    ST_SAW_IDLE = 2'd2,
    ST_RELEASE  = 2'd3
  } wait_state_t;
endpackage

// File: rtl/wsc_switch_sync.sv
module wsc_switch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_async,
  output logic lvl,
  output logic fell,
  output logic rose
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= sw_async;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign fell = prev & ~lvl;
  assign rose = ~prev & lvl;
endmodule

// File: rtl/wsc_entry.sv
module wsc_entry #(
  parameter int AW       = 17,
  parameter int TRAP_LOC = 'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic          is_indirect,
  input  logic          ind_ok,
  input  logic [AW-1:0] cur_pc,
  input  logic          busy,
  output logic          enter,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic          trap_req,
  output logic [AW-1:0] trap_vec
);
  localparam logic [AW-1:0] VEC = AW'(TRAP_LOC);
  logic accepted, bad_ref;

  assign accepted = issue_valid & ~busy;
  assign bad_ref  = is_indirect & ~ind_ok;
  assign enter    = accepted & ~bad_ref;
  assign trap_vec = VEC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_load  <= 1'b0;
      trap_req <= 1'b0;
      pc_value <= '0;
    end else begin
      pc_load  <= enter;
      trap_req <= accepted & bad_ref;
      if (enter) pc_value <= cur_pc + AW'(1);
    end
  end

  // R2: the load strobe is a single-cycle pulse
  assert_pc_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  // R9: a held-off issue leaves no trace
  assert_busy_issue_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && issue_valid) |=> (!pc_load && !trap_req));
endmodule

// File: rtl/wsc_wait_fsm.sv
module wsc_wait_fsm
  import wsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic irq,
  input  logic sw_fell,
  input  logic sw_rose,
  output logic stall,
  output logic resume
);
  wait_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_OFF:      if (enter) st_nx = ST_WAITING;
      ST_WAITING:  if (irq) st_nx = ST_RELEASE;
                   else if (sw_fell) st_nx = ST_SAW_IDLE;
      ST_SAW_IDLE: if (irq || sw_rose) st_nx = ST_RELEASE;
      ST_RELEASE:  st_nx = enter ? ST_WAITING : ST_OFF;
      default:     st_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= st_nx;
  end

  assign stall  = (st == ST_WAITING) || (st == ST_SAW_IDLE);
  assign resume = (st == ST_RELEASE);

  // R5: interrupt during the wait always releases
  assert_irq_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && irq) |=> resume);
  // R4: no release event, no release
  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !irq && !sw_rose) |=> stall);
  // R8: release lasts one cycle with stall low
  assert_resume_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!stall ##1 !resume));
endmodule

// File: rtl/wait_state_ctrl.sv
module wait_state_ctrl #(
  parameter int AW          = 17,
  parameter int TRAP_LOC    = 'h40,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic          is_indirect,
  input  logic          ind_ok,
  input  logic [AW-1:0] cur_pc,
  input  logic          irq,
  input  logic          sw_run,
  output logic          stall,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic          trap_req,
  output logic [AW-1:0] trap_vec,
  output logic          resume
);
  logic enter, sw_lvl, sw_fell, sw_rose;

  wsc_switch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sw_async(sw_run),
    .lvl(sw_lvl), .fell(sw_fell), .rose(sw_rose)
  );

  wsc_entry #(.AW(AW), .TRAP_LOC(TRAP_LOC)) u_entry (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
    .is_indirect(is_indirect), .ind_ok(ind_ok), .cur_pc(cur_pc),
    .busy(stall), .enter(enter), .pc_load(pc_load), .pc_value(pc_value),
    .trap_req(trap_req), .trap_vec(trap_vec)
  );

  wsc_wait_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enter(enter), .irq(irq),
    .sw_fell(sw_fell), .sw_rose(sw_rose), .stall(stall), .resume(resume)
  );

  logic unused_lvl;
  assign unused_lvl = sw_lvl;

  // R3: a trap never comes with a wait or a load
  assert_trap_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!stall && !pc_load));
  // R2: a load always opens a wait
  assert_load_with_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> stall);
endmodule

// File: tb/sim_wait_state_ctrl.sv
module sim_wait_state_ctrl;
  localparam int AW = 17;
  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 0, is_indirect = 0, ind_ok = 1, irq = 0, sw_run = 1;
  logic [AW-1:0] cur_pc = '0;
  logic stall, pc_load, trap_req, resume;
  logic [AW-1:0] pc_value, trap_vec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wait_state_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .is_indirect(is_indirect),
    .ind_ok(ind_ok), .cur_pc(cur_pc), .irq(irq), .sw_run(sw_run),
    .stall(stall), .pc_load(pc_load), .pc_value(pc_value),
    .trap_req(trap_req), .trap_vec(trap_vec), .resume(resume)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input logic [AW-1:0] pc, input logic ind, input logic ok);
    cur_pc = pc; is_indirect = ind; ind_ok = ok; issue_valid = 1;
    tick(1);
    issue_valid = 0; is_indirect = 0; ind_ok = 1;
  endtask

  task automatic t_reset;
    chk(stall == 0 && pc_load == 0 && trap_req == 0 && resume == 0, "R1 reset outputs",
        {stall, pc_load, trap_req, resume}, 0);
  endtask

  task automatic t_irq_release;
    issue(17'h00123, 0, 1);
    chk(pc_load == 1 && stall == 1, "R2 load+stall", {pc_load, stall}, 3);
    chk(pc_value == 17'h00124, "R2 pc_value", pc_value, 17'h00124);
    tick(1);
    chk(pc_load == 0, "R2 load single", pc_load, 0);
    tick(10);
    chk(stall == 1, "R4 stall held", stall, 1);
    issue(17'h00200, 1, 0);
    chk(pc_load == 0 && trap_req == 0, "R9 issue during stall", {pc_load, trap_req}, 0);
    irq = 1; tick(1); irq = 0;
    chk(resume == 1 && stall == 0, "R5 irq release", {resume, stall}, 2);
    tick(1);
    chk(resume == 0 && stall == 0, "R8 resume single", {resume, stall}, 0);
  endtask

  task automatic t_trap;
    issue(17'h00500, 1, 0);
    chk(trap_req == 1 && trap_vec == 17'h40, "R3 trap vector", trap_vec, 17'h40);
    chk(stall == 0 && pc_load == 0, "R3 no wait", {stall, pc_load}, 0);
    tick(1);
    chk(trap_req == 0, "R3 trap single", trap_req, 0);
  endtask

  task automatic t_wrap_indirect_ok;
    issue({AW{1'b1}}, 1, 1);
    chk(pc_load == 1 && pc_value == 0, "R2 wrap indirect ok", pc_value, 0);
    irq = 1; tick(1); irq = 0; tick(1);
  endtask

  task automatic t_switch;
    issue(17'h00010, 0, 1);
    sw_run = 0; tick(6);
    chk(stall == 1, "R6 idle alone holds", stall, 1);
    sw_run = 1; tick(2);
    chk(stall == 1, "R6 before latency", stall, 1);
    tick(1);
    chk(resume == 1 && stall == 0, "R6 switch release", {resume, stall}, 2);
    tick(1);
    chk(resume == 0, "R8 resume single sw", resume, 0);
  endtask

  task automatic t_idle_at_entry;
    sw_run = 0; tick(5);
    issue(17'h00020, 0, 1);
    sw_run = 1; tick(6);
    chk(stall == 1, "R7 return to run ignored", stall, 1);
    sw_run = 0; tick(5);
    sw_run = 1; tick(3);
    chk(resume == 1, "R7 later trip releases", resume, 1);
    tick(1);
  endtask

  task automatic t_irq_idle;
    irq = 1; tick(3); irq = 0;
    chk(stall == 0 && resume == 0, "R8 irq when idle", {stall, resume}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    t_reset;
    t_irq_release;
    t_trap;
    t_wrap_indirect_ok;
    t_switch;
    t_idle_at_entry;
    t_irq_idle;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule